// File: doc/BRIEF.md
# Funnel Shifter

This block shifts or rotates an N-bit word by an amount below N. It handles six operations: logical, arithmetic and rotate, each to the left or to the right. All six go through one datapath. A source word of almost twice the data width is assembled from the data and a fill pattern that depends on the operation. An N-bit window is then cut out of that source at an offset derived from the shift amount.

The window is picked by a cascade of log2(N) two-input multiplexer stages. Stage i is steered directly by bit i of the offset, so no one-hot decode of the amount is needed. For right operations the offset equals the amount. For left operations the source is pre-shifted one place right, which turns the offset into the bitwise complement of the amount and keeps it inside 0..N-1.

The result is registered. It appears one clock after the inputs are sampled, and a synchronous active-high reset clears it.

Top module: `funnel_shifter`

## Requirements
- R1: While rst is high at a rising clock edge, y_o becomes zero at that edge.
- R2: With kind_i = 2'b00 and left_i = 0, y_o is data_i shifted right by amt_i with zeros entering at the top.
- R3: With kind_i = 2'b01 and left_i = 0, y_o is data_i shifted right by amt_i with copies of data_i[N-1] entering at the top.
- R4: With kind_i = 2'b10 and left_i = 0, y_o is data_i rotated right by amt_i.
- R5: With kind_i = 2'b00 and left_i = 1, y_o is data_i shifted left by amt_i with zeros entering at the bottom.
- R6: With kind_i = 2'b01 and left_i = 1, y_o equals the logical left shift of data_i by amt_i.
- R7: With kind_i = 2'b10 and left_i = 1, y_o is data_i rotated left by amt_i.
- R8: With amt_i = 0, y_o equals data_i for every kind_i and both directions.
- R9: kind_i = 2'b11 gives the same result as kind_i = 2'b00 in both directions.
- R10: y_o reflects the inputs sampled at the previous rising clock edge and holds between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output register |
| data_i | input | N | Word to shift or rotate |
| amt_i | input | log2(N) | Shift amount, 0 to N-1 |
| left_i | input | 1 | 1 selects left, 0 selects right |
| kind_i | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 logical |
| y_o | output | N | Registered result |

## Verification
Every 8-bit data value is tried with every amount, both directions and all four kind codes, and each result is compared with the language's own shift and rotate operators. Words with the top bit set separate arithmetic from logical right shifts. Amounts near N-1 expose wrong fill bits or a wrong complemented offset on the left path. Amount zero confirms that the pre-shift on the left path does not lose the original word. A rotate with a nonzero amount differs from a shift whenever bits fall off the end, which catches a wrong fill selection. One check samples just before a clock edge to confirm that the output stays registered.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [1:0] {
    FS_LOGIC     = 2'b00,
    FS_ARITH     = 2'b01,
    FS_ROTATE    = 2'b10,
    FS_LOGIC_ALT = 2'b11
  } fs_kind_e;
endpackage

// File: rtl/fs_source_build.sv
module fs_source_build
  import fs_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]   data_i,
  input  logic           left_i,
  input  fs_kind_e       kind_i,
  output logic [2*N-2:0] src_o
);
  logic [N-1:0] fill;

  // fill pattern placed beside the data word
  always_comb begin
    unique case (kind_i)
      FS_ARITH:  fill = left_i ? '0 : {N{data_i[N-1]}};
      FS_ROTATE: fill = data_i;
      default:   fill = '0;
    endcase
  end

  // left: {data, fill} pre-shifted by one; right: {fill, data} minus top bit
  assign src_o = left_i ? {data_i, fill[N-1:1]} : {fill[N-2:0], data_i};
endmodule

// File: rtl/fs_window.sv
module fs_window #(
  parameter int N  = 8,
  parameter int SW = $clog2(N)
) (
  input  logic [2*N-2:0] src_i,
  input  logic [SW-1:0]  off_i,
  output logic [N-1:0]   win_o
);
  initial begin
    assert ((1 << SW) == N && N >= 2) else $error("N must be a power of two");
  end

  // each stage drops 2^i bits, optionally from the low end
  for (genvar i = 0; i < SW; i++) begin : g_st
    localparam int WI = 2*N - (1 << i);
    localparam int WO = 2*N - (2 << i);
    logic [WI-1:0] d;
    logic [WO-1:0] q;
    if (i == 0) begin : g_first
      assign d = src_i;
    end else begin : g_next
      assign d = g_st[i-1].q;
    end
    assign q = off_i[i] ? d[WI-1:(1 << i)] : d[WO-1:0];
  end

  assign win_o = g_st[SW-1].q;
endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
  import fs_pkg::*;
#(
  parameter int N = 8,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  input  logic          left_i,
  input  logic [1:0]    kind_i,
  output logic [N-1:0]  y_o
);
  fs_kind_e       kind;
  logic [2*N-2:0] src;
  logic [SW-1:0]  offset;
  logic [N-1:0]   win;

  assign kind   = fs_kind_e'(kind_i);
  assign offset = left_i ? ~amt_i : amt_i;

  fs_source_build #(.N(N)) u_src (
    .data_i (data_i),
    .left_i (left_i),
    .kind_i (kind),
    .src_o  (src)
  );

  fs_window #(.N(N), .SW(SW)) u_win (
    .src_i (src),
    .off_i (offset),
    .win_o (win)
  );

  always_ff @(posedge clk) begin
    if (rst) y_o <= '0;
    else     y_o <= win;
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (y_o == '0));

  a_r8_zero_amount: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(amt_i) == '0) |-> (y_o == $past(data_i)));

  a_r4_rotate_keeps_ones: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(kind_i) == 2'b10) |-> ($countones(y_o) == $countones($past(data_i))));

  a_r2_logic_right_top_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(kind_i[0]) == $past(kind_i[1]) && !$past(left_i) && $past(amt_i) != '0)
    |-> (y_o[N-1] == 1'b0));

  a_r3_arith_right_sign: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(kind_i) == 2'b01 && !$past(left_i)) |-> (y_o[N-1] == $past(data_i[N-1])));

  a_r5_left_low_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(kind_i) != 2'b10 && $past(left_i) && $past(amt_i) != '0)
    |-> (y_o[0] == 1'b0));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(data_i) && $stable(amt_i) && $stable(left_i) && $stable(kind_i))
    |=> $stable(y_o));
endmodule

// File: tb/funnel_shifter_tb.sv
`timescale 1ns/1ps
module funnel_shifter_tb;
  localparam int N  = 8;
  localparam int SW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  data_i = 8'hA5;
  logic [SW-1:0] amt_i = '0;
  logic          left_i = 1'b0;
  logic [1:0]    kind_i = 2'b00;
  logic [N-1:0]  y_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  funnel_shifter #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .data_i(data_i), .amt_i(amt_i),
    .left_i(left_i), .kind_i(kind_i), .y_o(y_o)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (d=%h k=%0d left=%0d kind=%0d)",
               tag, act, exp, data_i, amt_i, left_i, kind_i);
    end
  endtask

  function automatic logic [N-1:0] model(input logic [N-1:0] d, input int k,
                                         input logic lf, input logic [1:0] kd);
    logic [2*N-1:0] dd;
    dd = {d, d};
    if (kd == 2'b10) begin
      if (lf) begin dd = dd << k; return dd[2*N-1:N]; end
      else    begin dd = dd >> k; return dd[N-1:0];   end
    end
    if (lf) return d << k;
    if (kd == 2'b01) return $unsigned($signed(d) >>> k);
    return d >> k;
  endfunction

  function automatic string tag_of(input int k, input logic lf, input logic [1:0] kd);
    if (k == 0)     return "R8";
    if (kd == 2'b11) return "R9";
    case ({lf, kd})
      3'b000:  return "R2";
      3'b001:  return "R3";
      3'b010:  return "R4";
      3'b100:  return "R5";
      3'b101:  return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", y_o, '0);
    rst = 1'b0;

    for (int kd = 0; kd < 4; kd++) begin
      for (int lf = 0; lf < 2; lf++) begin
        for (int k = 0; k < N; k++) begin
          for (int d = 0; d < (1 << N); d++) begin
            data_i = d[N-1:0];
            amt_i  = k[SW-1:0];
            left_i = lf[0];
            kind_i = kd[1:0];
            @(negedge clk);
            check(tag_of(k, lf[0], kd[1:0]), y_o, model(d[N-1:0], k, lf[0], kd[1:0]));
          end
        end
      end
    end

    // R10: new inputs do not reach the output before the next edge
    data_i = 8'h81; amt_i = 3'd1; left_i = 1'b0; kind_i = 2'b01;
    @(negedge clk);
    data_i = 8'h0F; amt_i = 3'd4; left_i = 1'b1; kind_i = 2'b00;
    #1;
    check("R10", y_o, 8'hC0);
    @(negedge clk);
    check("R10", y_o, 8'hF0);

    // R1: reset in mid run clears a nonzero result
    rst = 1'b1;
    @(negedge clk);
    check("R1", y_o, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R5", y_o, 8'hF0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule